// File: doc/BRIEF.md
# PTP Frame Timestamp Capture

This block sits beside an Ethernet MAC at the point where frames cross the transmit and receive timestamp boundary. When the MAC strobes that a frame is passing in one direction, the block samples the free-running time of day (seconds and nanoseconds) and stores it in a capture register pair. Each direction keeps two pairs: one for ordinary event messages and one for peer-delay event messages. The class is chosen by the message-type byte that the upstream parser supplies with each strobe.

On every strobe the block also forms the two words that the DMA engine writes back into an extended buffer descriptor. The low word holds the 30 nanosecond bits with seconds bits [1:0] on top. The high word holds seconds bits [5:2] in its four low bits. Software rebuilds the full timestamp by taking seconds bits [5:0] from the descriptor and the upper seconds from the matching capture register. A per-direction mode decides which frames get a descriptor timestamp. A receive flag, meant for bit 2 of the descriptor address word, marks a receive descriptor that carries a valid stamp.

Top module: `ptp_stamp_latch`

## Requirements
- R1: After reset every capture register, every descriptor word and `rx_ts_valid` read zero.
- R2: A transmit strobe with `tx_is_ptp`=1, message-type bits [3:2]=00 (event message) and bit [1]=0 loads `tod_sec`/`tod_ns` of that clock edge into `tx_ev_sec`/`tx_ev_ns`, visible the next cycle.
- R3: When message-type bit [1]=1, an event frame loads the peer pair (`tx_pe_*` or `rx_pe_*`) instead, and the ordinary pair of that direction keeps its value.
- R4: A receive strobe loads `rx_ev_*` or `rx_pe_*` under the same rules as R2 and R3. The two directions are independent, and both may strobe in the same cycle.
- R5: A capture register changes only on a qualifying strobe of its own direction and class. Strobes for non-PTP frames, or for general messages (type bits [3:2] not 00), leave all four pairs unchanged.
- R6: A stamped descriptor has low word = {sec[1:0], ns[29:0]} and high word = {28'b0, sec[5:2]}, taken from the time of the strobe edge.
- R7: Mode 01 stamps only PTP event frames (type bits [3:2]=00).
- R8: Mode 10 stamps every frame with `*_is_ptp`=1, including general messages.
- R9: On a strobe whose frame the mode does not select (mode 00, mode 11, non-PTP, or a general message in mode 01), both descriptor words of that direction become zero and, for receive, `rx_ts_valid` clears.
- R10: `rx_ts_valid` is set after a receive strobe whose frame was stamped.
- R11: The descriptor words and `rx_ts_valid` hold their value between strobes of their direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tod_sec | input | SEC_W | Time counter seconds |
| tod_ns | input | 30 | Time counter nanoseconds |
| tx_stb | input | 1 | Transmit frame passes the timestamp point |
| tx_is_ptp | input | 1 | Transmit frame is PTP |
| tx_msg_type | input | 8 | Transmit PTP message-type byte |
| tx_mode | input | 2 | Transmit descriptor mode: 00 none, 01 event, 10 all PTP, 11 none |
| rx_stb | input | 1 | Receive frame passes the timestamp point |
| rx_is_ptp | input | 1 | Receive frame is PTP |
| rx_msg_type | input | 8 | Receive PTP message-type byte |
| rx_mode | input | 2 | Receive descriptor mode, same encoding |
| tx_ev_sec | output | SEC_W | Transmit event capture, seconds |
| tx_ev_ns | output | 30 | Transmit event capture, nanoseconds |
| tx_pe_sec | output | SEC_W | Transmit peer event capture, seconds |
| tx_pe_ns | output | 30 | Transmit peer event capture, nanoseconds |
| rx_ev_sec | output | SEC_W | Receive event capture, seconds |
| rx_ev_ns | output | 30 | Receive event capture, nanoseconds |
| rx_pe_sec | output | SEC_W | Receive peer event capture, seconds |
| rx_pe_ns | output | 30 | Receive peer event capture, nanoseconds |
| tx_desc_lo | output | 32 | Transmit descriptor low timestamp word |
| tx_desc_hi | output | 32 | Transmit descriptor high timestamp word |
| rx_desc_lo | output | 32 | Receive descriptor low timestamp word |
| rx_desc_hi | output | 32 | Receive descriptor high timestamp word |
| rx_ts_valid | output | 1 | Receive descriptor holds a valid timestamp |

## Verification
The assertions assume that the strobes and their frame qualifiers are steady across the clock edge at which they are sampled. They also assume the time inputs are defined whenever a strobe is high. The bench drives every input on the falling edge and keeps it for a full cycle, so this holds. Random time values, message types of every class and all four mode codes are mixed with directed cases: both directions strobing together, mode 11, and general messages in modes 01 and 10.

// File: rtl/ptp_stamp_latch.sv
module ptp_stamp_latch #(
  parameter int SEC_W = 48
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEC_W-1:0] tod_sec,
  input  logic [29:0]      tod_ns,
  input  logic             tx_stb,
  input  logic             tx_is_ptp,
  input  logic [7:0]       tx_msg_type,
  input  logic [1:0]       tx_mode,
  input  logic             rx_stb,
  input  logic             rx_is_ptp,
  input  logic [7:0]       rx_msg_type,
  input  logic [1:0]       rx_mode,
  output logic [SEC_W-1:0] tx_ev_sec,
  output logic [29:0]      tx_ev_ns,
  output logic [SEC_W-1:0] tx_pe_sec,
  output logic [29:0]      tx_pe_ns,
  output logic [SEC_W-1:0] rx_ev_sec,
  output logic [29:0]      rx_ev_ns,
  output logic [SEC_W-1:0] rx_pe_sec,
  output logic [29:0]      rx_pe_ns,
  output logic [31:0]      tx_desc_lo,
  output logic [31:0]      tx_desc_hi,
  output logic [31:0]      rx_desc_lo,
  output logic [31:0]      rx_desc_hi,
  output logic             rx_ts_valid
);
  localparam int NS_W   = 30;
  localparam int WORD_W = 32;
  localparam int LO_SEC = WORD_W - NS_W;
  localparam int HI_SEC = 6 - LO_SEC;

  localparam logic [1:0] MODE_EVENT = 2'b01;
  localparam logic [1:0] MODE_ALL   = 2'b10;

  function automatic logic stamp_sel(logic [1:0] mode, logic ptp, logic [7:0] mt);
    return ptp && ((mode == MODE_EVENT && mt[3:2] == 2'b00) || mode == MODE_ALL);
  endfunction

  logic tx_evt, rx_evt, tx_take, rx_take;
  logic [WORD_W-1:0] lo_word, hi_word;
  logic unused_type_bits;

  assign tx_evt  = tx_stb && tx_is_ptp && tx_msg_type[3:2] == 2'b00;
  assign rx_evt  = rx_stb && rx_is_ptp && rx_msg_type[3:2] == 2'b00;
  assign tx_take = stamp_sel(tx_mode, tx_is_ptp, tx_msg_type);
  assign rx_take = stamp_sel(rx_mode, rx_is_ptp, rx_msg_type);
  assign lo_word = {tod_sec[LO_SEC-1:0], tod_ns};
  assign hi_word = {{(WORD_W-HI_SEC){1'b0}}, tod_sec[LO_SEC+HI_SEC-1:LO_SEC]};
  assign unused_type_bits = ^{tx_msg_type[7:4], tx_msg_type[0], rx_msg_type[7:4], rx_msg_type[0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_ev_sec <= '0; tx_ev_ns <= '0; tx_pe_sec <= '0; tx_pe_ns <= '0;
      rx_ev_sec <= '0; rx_ev_ns <= '0; rx_pe_sec <= '0; rx_pe_ns <= '0;
    end else begin
      if (tx_evt && !tx_msg_type[1]) begin tx_ev_sec <= tod_sec; tx_ev_ns <= tod_ns; end
      if (tx_evt &&  tx_msg_type[1]) begin tx_pe_sec <= tod_sec; tx_pe_ns <= tod_ns; end
      if (rx_evt && !rx_msg_type[1]) begin rx_ev_sec <= tod_sec; rx_ev_ns <= tod_ns; end
      if (rx_evt &&  rx_msg_type[1]) begin rx_pe_sec <= tod_sec; rx_pe_ns <= tod_ns; end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_desc_lo <= '0; tx_desc_hi <= '0;
      rx_desc_lo <= '0; rx_desc_hi <= '0; rx_ts_valid <= 1'b0;
    end else begin
      if (tx_stb) begin
        tx_desc_lo <= tx_take ? lo_word : '0;
        tx_desc_hi <= tx_take ? hi_word : '0;
      end
      if (rx_stb) begin
        rx_desc_lo  <= rx_take ? lo_word : '0;
        rx_desc_hi  <= rx_take ? hi_word : '0;
        rx_ts_valid <= rx_take;
      end
    end
  end

  assert_tx_event_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_stb && tx_is_ptp && tx_msg_type[3:2] == 2'b00 && !tx_msg_type[1])
    |=> (tx_ev_sec == $past(tod_sec) && tx_ev_ns == $past(tod_ns)));

  assert_peer_keeps_event_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!rx_stb || rx_msg_type[1] || !rx_is_ptp) |=> $stable(rx_ev_ns) && $stable(rx_ev_sec));

  assert_rx_peer_capture_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stb && rx_is_ptp && rx_msg_type[3:2] == 2'b00 && rx_msg_type[1])
    |=> (rx_pe_ns == $past(tod_ns) && rx_pe_sec == $past(tod_sec)));

  assert_no_stray_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_stb |=> $stable(tx_ev_ns) && $stable(tx_pe_ns));

  assert_unselected_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stb && (rx_mode == 2'b00 || !rx_is_ptp)) |=> (!rx_ts_valid && rx_desc_lo == '0 && rx_desc_hi == '0));

  assert_mode_all_stamps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_stb && rx_is_ptp && rx_mode == MODE_ALL)
    |=> (rx_ts_valid && rx_desc_lo == {$past(tod_sec[1:0]), $past(tod_ns)}));

  assert_desc_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_stb |=> $stable(rx_desc_lo) && $stable(rx_ts_valid));
endmodule

// File: tb/ptp_stamp_latch_tb_top.sv
module ptp_stamp_latch_tb_top;
  localparam int SEC_W = 48;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [SEC_W-1:0] tod_sec = '0;
  logic [29:0] tod_ns = '0;
  logic tx_stb = 0, tx_is_ptp = 0, rx_stb = 0, rx_is_ptp = 0;
  logic [7:0] tx_msg_type = 0, rx_msg_type = 0;
  logic [1:0] tx_mode = 0, rx_mode = 0;
  logic [SEC_W-1:0] tx_ev_sec, tx_pe_sec, rx_ev_sec, rx_pe_sec;
  logic [29:0] tx_ev_ns, tx_pe_ns, rx_ev_ns, rx_pe_ns;
  logic [31:0] tx_desc_lo, tx_desc_hi, rx_desc_lo, rx_desc_hi;
  logic rx_ts_valid;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [SEC_W-1:0] m_tes, m_tps, m_res, m_rps;
  logic [29:0] m_ten, m_tpn, m_ren, m_rpn;
  logic [31:0] m_tlo, m_thi, m_rlo, m_rhi;
  logic m_val;

  always #5 clk = ~clk;

  ptp_stamp_latch #(.SEC_W(SEC_W)) dut_i (.*);

  function automatic bit exp_sel(logic [1:0] mode, logic ptp, logic [7:0] mt);
    if (!ptp) return 0;
    if (mode == 2'b01) return mt[3:2] == 2'b00;
    return mode == 2'b10;
  endfunction

  function automatic logic [31:0] exp_lo(logic [SEC_W-1:0] s, logic [29:0] n);
    return {s[1:0], n};
  endfunction

  function automatic logic [31:0] exp_hi(logic [SEC_W-1:0] s);
    return {28'd0, s[5:2]};
  endfunction

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(string tag);
    chk({tag, " R2 tx_ev_sec"}, 64'(tx_ev_sec), 64'(m_tes));
    chk({tag, " R2 tx_ev_ns"}, 64'(tx_ev_ns), 64'(m_ten));
    chk({tag, " R3 tx_pe"}, {tx_pe_sec[33:0], tx_pe_ns}, {m_tps[33:0], m_tpn});
    chk({tag, " R4 rx_ev"}, {rx_ev_sec[33:0], rx_ev_ns}, {m_res[33:0], m_ren});
    chk({tag, " R4 rx_pe"}, {rx_pe_sec[33:0], rx_pe_ns}, {m_rps[33:0], m_rpn});
    chk({tag, " R5 upper secs"}, {16'd0, tx_ev_sec[47:34], tx_pe_sec[47:34], rx_ev_sec[47:34]},
        {16'd0, m_tes[47:34], m_tps[47:34], m_res[47:34]});
    chk({tag, " R6 tx desc"}, {tx_desc_hi, tx_desc_lo}, {m_thi, m_tlo});
    chk({tag, " R6 rx desc"}, {rx_desc_hi, rx_desc_lo}, {m_rhi, m_rlo});
    chk({tag, " R10 rx_ts_valid"}, 64'(rx_ts_valid), 64'(m_val));
  endtask

  task automatic drive(logic ts, logic tp, logic [7:0] tm, logic [1:0] tmd,
                       logic rs, logic rp, logic [7:0] rm, logic [1:0] rmd);
    tod_sec = {$urandom, $urandom} & {SEC_W{1'b1}};
    tod_ns = 30'($urandom % 1000000000);
    tx_stb = ts; tx_is_ptp = tp; tx_msg_type = tm; tx_mode = tmd;
    rx_stb = rs; rx_is_ptp = rp; rx_msg_type = rm; rx_mode = rmd;
    if (ts && tp && tm[3:2] == 2'b00) begin
      if (tm[1]) begin m_tps = tod_sec; m_tpn = tod_ns; end
      else begin m_tes = tod_sec; m_ten = tod_ns; end
    end
    if (rs && rp && rm[3:2] == 2'b00) begin
      if (rm[1]) begin m_rps = tod_sec; m_rpn = tod_ns; end
      else begin m_res = tod_sec; m_ren = tod_ns; end
    end
    if (ts) begin
      m_tlo = exp_sel(tmd, tp, tm) ? exp_lo(tod_sec, tod_ns) : 32'd0;
      m_thi = exp_sel(tmd, tp, tm) ? exp_hi(tod_sec) : 32'd0;
    end
    if (rs) begin
      m_val = exp_sel(rmd, rp, rm);
      m_rlo = m_val ? exp_lo(tod_sec, tod_ns) : 32'd0;
      m_rhi = m_val ? exp_hi(tod_sec) : 32'd0;
    end
  endtask

  task automatic step(string tag, logic ts, logic tp, logic [7:0] tm, logic [1:0] tmd,
                      logic rs, logic rp, logic [7:0] rm, logic [1:0] rmd);
    @(negedge clk);
    drive(ts, tp, tm, tmd, rs, rp, rm, rmd);
    @(negedge clk);
    chk_all(tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    m_tes = '0; m_tps = '0; m_res = '0; m_rps = '0;
    m_ten = '0; m_tpn = '0; m_ren = '0; m_rpn = '0;
    m_tlo = '0; m_thi = '0; m_rlo = '0; m_rhi = '0; m_val = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk_all("R1 reset");
    step("R2 tx event mode01", 1, 1, 8'h00, 2'b01, 0, 0, 8'h00, 2'b00);
    step("R3 tx peer", 1, 1, 8'h02, 2'b01, 0, 0, 8'h00, 2'b00);
    step("R4 both dirs", 1, 1, 8'h01, 2'b10, 1, 1, 8'h03, 2'b01);
    step("R5 R7 general mode01", 1, 1, 8'h0b, 2'b01, 1, 1, 8'h08, 2'b01);
    step("R8 general mode10", 1, 1, 8'h0c, 2'b10, 1, 1, 8'h09, 2'b10);
    step("R9 mode11", 1, 1, 8'h00, 2'b11, 1, 1, 8'h02, 2'b11);
    step("R10 rx stamp", 0, 0, 8'h00, 2'b00, 1, 1, 8'h00, 2'b01);
    step("R9 R5 non-ptp", 1, 0, 8'h00, 2'b10, 1, 0, 8'h02, 2'b10);
    step("R10 rx stamp again", 0, 0, 8'h00, 2'b00, 1, 1, 8'h01, 2'b10);
    step("R11 hold", 0, 1, 8'h00, 2'b10, 0, 1, 8'h00, 2'b10);
    step("R9 mode00", 1, 1, 8'h00, 2'b00, 1, 1, 8'h00, 2'b00);
    for (int i = 0; i < 400; i++) begin
      step("random", 1'($urandom), 1'($urandom), 8'($urandom % 16), 2'($urandom),
           1'($urandom), 1'($urandom), 8'($urandom % 16), 2'($urandom));
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule